// File: doc/BRIEF.md
# SPI Command Engine with Byte-Register Window

This block is an SPI master that software drives through eight byte-wide registers. Software first writes an opcode, up to three address bytes and one extra byte into their registers. It then writes a control byte. The control byte chooses how many bytes go out, how many bytes come back and which of two serial clock rates to use, and it starts the transfer. The engine shifts the bytes out on MOSI with the clock in SPI mode 0, most significant bit first. Chip select stays low for the whole command.

Software polls a busy bit until the transfer ends. It then reads the bytes that were clocked in from the device. Only four outgoing lengths exist: 1, 2, 4 and 5 bytes. The address registers are sent highest offset first. At most three bytes are received, and the last of them shares its register with the extra outgoing byte.

The serial clock comes from the system clock. Each half period lasts `HALF_FAST` or `HALF_SLOW` system cycles, and the speed bit of the control byte picks which.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, all eight offsets read 0x00, chip select is high and the serial clock is low.
- R2: A write to offset 0 starts a transfer only when bits 7:4 hold 0x4 (slow rate) or 0x5 (fast rate). Any other value leaves the link idle.
- R3: Bits 1:0 of the control byte select 1, 2, 4 or 5 bytes sent for codes 0, 1, 2 and 3. Bits 3:2 give the number of bytes read, 0 to 3. A transfer produces exactly 8 x (sent + read) clock pulses.
- R4: The opcode at offset 1 is sent first. Lengths 4 and 5 then send offsets 4, 3 and 2, in that order. The offset 7 byte is sent second in a 2-byte command and last in a 5-byte command. Every byte goes out most significant bit first.
- R5: MOSI is held low during the read bytes, and MISO is ignored during the sent bytes. Received bytes land at offsets 5, 6 and 7 in arrival order. Offsets beyond the read count keep their previous values.
- R6: Bit 7 of offset 0 reads 1 from the cycle after the starting write until 2 x H x bits cycles have passed. H is `HALF_FAST` for code 0x5 and `HALF_SLOW` for code 0x4.
- R7: Writes to offset 0 while a transfer runs are ignored. They neither restart nor extend the transfer.
- R8: SPI mode 0 is used. The serial clock is low whenever chip select is high. MOSI changes only while the clock is low.
- R9: Offsets 1 to 4 and offset 7 read back what was written. Writes to offsets 5 and 6 are ignored. Offset 0 reads busy in bit 7 and zero in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Busy appears at offset 0 on the clock edge that takes the control write. The first rising serial clock edge follows H cycles later, and busy falls 2 x H x bits cycles after the start. Each received byte is stored one cycle after its last sampling edge, which is always before busy clears. The bench drives and samples on the falling system clock edge. It counts how many of those edges it polls with busy set and compares the count with the exact figure. It reads the received bytes, and the wire stream captured by its device model, only after busy has cleared.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int BYTE_W  = 8;
   localparam int ADDR_W  = 3;
   localparam int TX_MAX  = 5;
   localparam int RX_MAX  = 3;
   localparam int TX_BITS = TX_MAX * BYTE_W;
   localparam int CNT_W   = $clog2((TX_MAX + RX_MAX) * BYTE_W);

   typedef logic [BYTE_W-1:0] byte_t;

   localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_OP   = 3'd1;
   localparam logic [ADDR_W-1:0] OFS_A2   = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_A3   = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_A4   = 3'd4;
   localparam logic [ADDR_W-1:0] OFS_RX0  = 3'd5;
   localparam logic [ADDR_W-1:0] OFS_RX1  = 3'd6;
   localparam logic [ADDR_W-1:0] OFS_X    = 3'd7;

   localparam logic [3:0] GO_SLOW = 4'h4;
   localparam logic [3:0] GO_FAST = 4'h5;

   // outgoing byte count for a 2-bit length code
   function automatic logic [2:0] tx_len(input logic [1:0] code);
      case (code)
         2'd0:    tx_len = 3'd1;
         2'd1:    tx_len = 3'd2;
         2'd2:    tx_len = 3'd4;
         default: tx_len = 3'd5;
      endcase
   endfunction
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
   import spi_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  byte_t             host_wdata,
   input  logic              busy,
   input  logic              rx_we,
   input  logic [1:0]        rx_idx,
   input  byte_t             rx_byte,
   output byte_t             host_rdata,
   output byte_t             op,
   output byte_t             a2,
   output byte_t             a3,
   output byte_t             a4,
   output byte_t             xb
);
   logic [RX_MAX*BYTE_W-1:0] bank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op <= '0;
         a2 <= '0;
         a3 <= '0;
         a4 <= '0;
      end else if (host_wr) begin
         case (host_addr)
            OFS_OP:  op <= host_wdata;
            OFS_A2:  a2 <= host_wdata;
            OFS_A3:  a3 <= host_wdata;
            OFS_A4:  a4 <= host_wdata;
            default: ;
         endcase
      end
   end

   // receive bank; the top slot doubles as the extra outgoing byte
   for (genvar g = 0; g < RX_MAX; g++) begin : g_rx
      byte_t q;
      if (g == RX_MAX - 1) begin : g_shared
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (rx_we && rx_idx == 2'(g))
               q <= rx_byte;
            else if (host_wr && host_addr == OFS_X)
               q <= host_wdata;
         end
      end else begin : g_ro
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (rx_we && rx_idx == 2'(g))
               q <= rx_byte;
         end
      end
      assign bank[g*BYTE_W +: BYTE_W] = q;
   end

   assign xb = bank[(RX_MAX-1)*BYTE_W +: BYTE_W];

   always_comb begin
      case (host_addr)
         OFS_CTRL: host_rdata = {busy, 7'd0};
         OFS_OP:   host_rdata = op;
         OFS_A2:   host_rdata = a2;
         OFS_A3:   host_rdata = a3;
         OFS_A4:   host_rdata = a4;
         OFS_RX0:  host_rdata = bank[0 +: BYTE_W];
         OFS_RX1:  host_rdata = bank[BYTE_W +: BYTE_W];
         default:  host_rdata = xb;
      endcase
   end
endmodule

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
   parameter int HALF_FAST = 4,
   parameter int HALF_SLOW = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   output logic tick
);
   localparam int CW = $clog2(HALF_SLOW + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   if (HALF_FAST == HALF_SLOW) begin : g_one_rate
      assign lim = CW'(HALF_FAST - 1);
   end else begin : g_two_rate
      assign lim = fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
   end

   assign tick = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
   import spi_cmd_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               fast_in,
   input  logic [2:0]         nwr,
   input  logic [1:0]         nrd,
   input  logic [TX_BITS-1:0] tx_bits,
   input  logic               tick,
   input  logic               miso,
   output logic               busy,
   output logic               fast,
   output logic               sck,
   output logic               cs_n,
   output logic               mosi,
   output logic               rx_we,
   output logic [1:0]         rx_idx,
   output byte_t              rx_byte
);
   logic [TX_BITS-1:0] sr;
   logic [CNT_W-1:0]   bitcnt;
   logic [CNT_W-1:0]   last;
   logic [CNT_W-1:0]   wrbits;
   byte_t              rxsh;
   logic [3:0]         nbytes;
   logic               rise;
   logic               fall;
   logic               in_rd;

   assign nbytes = {1'b0, nwr} + {2'b00, nrd};
   assign rise   = busy && tick && !sck;
   assign fall   = busy && tick && sck;
   assign in_rd  = bitcnt >= wrbits;
   assign mosi   = sr[TX_BITS-1];
   assign cs_n   = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         fast    <= 1'b0;
         sck     <= 1'b0;
         sr      <= '0;
         bitcnt  <= '0;
         last    <= '0;
         wrbits  <= '0;
         rxsh    <= '0;
         rx_we   <= 1'b0;
         rx_idx  <= '0;
         rx_byte <= '0;
      end else begin
         rx_we <= 1'b0;
         if (start && !busy) begin
            busy   <= 1'b1;
            fast   <= fast_in;
            sck    <= 1'b0;
            sr     <= tx_bits;
            bitcnt <= '0;
            last   <= CNT_W'({nbytes, 3'b000} - 7'd1);
            wrbits <= CNT_W'({nwr, 3'b000});
         end else if (rise) begin
            sck <= 1'b1;
            if (in_rd) begin
               rxsh <= {rxsh[BYTE_W-2:0], miso};
               if (bitcnt[2:0] == 3'd7) begin
                  rx_we   <= 1'b1;
                  rx_byte <= {rxsh[BYTE_W-2:0], miso};
                  rx_idx  <= 2'(bitcnt[CNT_W-1:3] - wrbits[CNT_W-1:3]);
               end
            end
         end else if (fall) begin
            sck <= 1'b0;
            if (bitcnt == last) begin
               busy <= 1'b0;
            end else begin
               bitcnt <= bitcnt + 1'b1;
               sr     <= {sr[TX_BITS-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int HALF_FAST = 4,
   parameter int HALF_SLOW = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_wr,
   input  logic [2:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       spi_sck,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   if (HALF_FAST < 1) begin : g_bad_fast
      $error("HALF_FAST must be at least 1");
   end
   if (HALF_SLOW < HALF_FAST) begin : g_bad_slow
      $error("HALF_SLOW must not be below HALF_FAST");
   end

   byte_t              op, a2, a3, a4, xb;
   logic               busy, fast, tick, go;
   logic               rx_we;
   logic [1:0]         rx_idx;
   byte_t              rx_byte;
   logic [TX_BITS-1:0] tx_bits;
   logic [3:0]         code;

   assign code = host_wdata[7:4];
   assign go   = host_wr && (host_addr == OFS_CTRL) && !busy &&
                 (code == GO_SLOW || code == GO_FAST);

   // outgoing stream, left-justified, in wire order
   always_comb begin
      case (host_wdata[1:0])
         2'd0:    tx_bits = {op, 32'd0};
         2'd1:    tx_bits = {op, xb, 24'd0};
         2'd2:    tx_bits = {op, a4, a3, a2, 8'd0};
         default: tx_bits = {op, a4, a3, a2, xb};
      endcase
   end

   spi_cmd_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .busy(busy), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
      .host_rdata(host_rdata),
      .op(op), .a2(a2), .a3(a3), .a4(a4), .xb(xb)
   );

   spi_cmd_tick #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .fast(fast), .tick(tick)
   );

   spi_cmd_shift u_shift (
      .clk(clk), .rst_n(rst_n),
      .start(go), .fast_in(code == GO_FAST),
      .nwr(tx_len(host_wdata[1:0])), .nrd(host_wdata[3:2]),
      .tx_bits(tx_bits), .tick(tick), .miso(spi_miso),
      .busy(busy), .fast(fast), .sck(spi_sck), .cs_n(spi_cs_n),
      .mosi(spi_mosi), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
   );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_wr,
   input logic [2:0] host_addr,
   input logic [7:0] host_wdata,
   input logic       busy,
   input logic       spi_sck,
   input logic       spi_cs_n,
   input logic       spi_mosi
);
   logic ctrl_wr, code_ok, go_ok, bad_go;

   assign ctrl_wr = host_wr && host_addr == 3'd0 && !busy;
   assign code_ok = host_wdata[7:4] == 4'h4 || host_wdata[7:4] == 4'h5;
   assign go_ok   = ctrl_wr && code_ok;
   assign bad_go  = ctrl_wr && !code_ok;

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      go_ok |=> !spi_cs_n);

   assert_bad_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bad_go |=> spi_cs_n);

   assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> $past(go_ok));

   assert_idle_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
   .host_wdata(host_wdata), .busy(busy), .spi_sck(spi_sck),
   .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
   localparam int HF = 4;
   localparam int HS = 8;

   // {ctrl, op, a2, a3, a4, extra, resp0, resp1, resp2}
   localparam logic [71:0] VEC [6] = '{
      {8'h50, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
      {8'h4D, 8'hAB, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h11, 8'h22, 8'h33},
      {8'h5A, 8'h03, 8'h56, 8'h34, 8'h12, 8'h77, 8'hC3, 8'h5A, 8'h00},
      {8'h4F, 8'h0B, 8'h03, 8'h02, 8'h01, 8'hEE, 8'h81, 8'h42, 8'h24},
      {8'h57, 8'h02, 8'h10, 8'h20, 8'h30, 8'h99, 8'h5E, 8'h00, 8'h00},
      {8'h44, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h66, 8'hEF, 8'h00, 8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       host_wr;
   logic [2:0] host_addr;
   logic [7:0] host_wdata;
   logic [7:0] host_rdata;
   logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

   always #2 clk = ~clk;

   spi_cmd_engine #(.HALF_FAST(HF), .HALF_SLOW(HS)) dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sck(spi_sck),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // device model: captures MOSI on rising SCK, shifts MISO on falling SCK
   logic [63:0] cap = '0;
   int          cap_n = 0;
   int          fall_n = 0;
   int          fall_base = 0;
   int          sidx;
   logic [63:0] pat = '0;
   logic [7:0]  m [8];

   always @(posedge spi_sck) begin
      cap   <= {cap[62:0], spi_mosi};
      cap_n <= cap_n + 1;
   end
   always @(negedge spi_sck) fall_n <= fall_n + 1;
   always_comb begin
      sidx     = fall_n - fall_base;
      spi_miso = (sidx >= 0 && sidx < 64) ? pat[63 - sidx] : 1'b0;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      host_addr  = a;
      host_wdata = d;
      host_wr    = 1'b1;
      @(negedge clk);
      host_wr    = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic wait_idle(output int cyc);
      logic [7:0] s;
      cyc = 0;
      rd(3'd0, s);
      while (s[7] && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         rd(3'd0, s);
      end
   endtask

   task automatic run_vec(input logic [71:0] v);
      logic [7:0]  c, op, a2, a3, a4, x, r0, r1, r2, d;
      logic [39:0] seq;
      logic [63:0] exp, mask, resp;
      int          nw, nr, bits, half, cyc, cap_b;
      {c, op, a2, a3, a4, x, r0, r1, r2} = v;
      nw   = (c[1:0] == 2'd0) ? 1 : (c[1:0] == 2'd1) ? 2 : (c[1:0] == 2'd2) ? 4 : 5;
      nr   = int'(c[3:2]);
      bits = 8 * (nw + nr);
      half = c[4] ? HF : HS;
      case (c[1:0])
         2'd0:    seq = {32'd0, op};
         2'd1:    seq = {24'd0, op, x};
         2'd2:    seq = {8'd0, op, a4, a3, a2};
         default: seq = {op, a4, a3, a2, x};
      endcase
      exp  = {24'd0, seq} << (8 * nr);
      resp = {r0, r1, r2, 40'd0};
      pat  = (resp >> (8 * nw)) | ~({64{1'b1}} >> (8 * nw));
      wr(3'd1, op); wr(3'd2, a2); wr(3'd3, a3); wr(3'd4, a4); wr(3'd7, x);
      m[1] = op; m[2] = a2; m[3] = a3; m[4] = a4; m[7] = x;
      fall_base = fall_n;
      cap_b     = cap_n;
      wr(3'd0, c);
      wait_idle(cyc);
      chk("R6 busy duration", 64'(cyc), 64'(2 * half * bits));
      chk("R3 clock pulse count", 64'(cap_n - cap_b), 64'(bits));
      mask = (bits >= 64) ? {64{1'b1}} : ((64'd1 << bits) - 64'd1);
      chk("R4 R5 wire stream", cap & mask, exp);
      if (nr > 0) m[5] = r0;
      if (nr > 1) m[6] = r1;
      if (nr > 2) m[7] = r2;
      for (int k = 5; k < 8; k++) begin
         rd(3'(k), d);
         chk("R5 received byte", 64'(d), 64'(m[k]));
      end
      chk("R8 idle after transfer", 64'({spi_cs_n, spi_sck}), 64'b10);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int         cyc, cap_b;
      host_wr = 1'b0; host_addr = '0; host_wdata = '0;
      rst_n = 1'b0;
      for (int k = 0; k < 8; k++) m[k] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 chip select high", 64'(spi_cs_n), 64'd1);
      chk("R1 clock low", 64'(spi_sck), 64'd0);
      for (int k = 0; k < 8; k++) begin
         rd(3'(k), d);
         chk("R1 offset cleared", 64'(d), 64'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R9 readback and read-only receive slots
      wr(3'd1, 8'hA1); wr(3'd2, 8'hB2); wr(3'd3, 8'hC3); wr(3'd4, 8'hD4); wr(3'd7, 8'hE7);
      wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
      rd(3'd1, d); chk("R9 offset 1", 64'(d), 64'hA1);
      rd(3'd2, d); chk("R9 offset 2", 64'(d), 64'hB2);
      rd(3'd3, d); chk("R9 offset 3", 64'(d), 64'hC3);
      rd(3'd4, d); chk("R9 offset 4", 64'(d), 64'hD4);
      rd(3'd7, d); chk("R9 offset 7", 64'(d), 64'hE7);
      rd(3'd5, d); chk("R9 offset 5 write ignored", 64'(d), 64'h00);
      rd(3'd6, d); chk("R9 offset 6 write ignored", 64'(d), 64'h00);
      rd(3'd0, d); chk("R9 control idle read", 64'(d), 64'h00);

      // R2 control values that must not start
      cap_b = cap_n;
      wr(3'd0, 8'h6D);
      wr(3'd0, 8'h0F);
      wr(3'd0, 8'hCF);
      repeat (40) @(negedge clk);
      rd(3'd0, d);
      chk("R2 bad code busy", 64'(d), 64'h00);
      chk("R2 bad code no clock", 64'(cap_n - cap_b), 64'd0);
      chk("R2 bad code chip select", 64'(spi_cs_n), 64'd1);

      // main vector table
      for (int i = 0; i < 6; i++) run_vec(VEC[i]);

      // R7 control write during a transfer is ignored
      wr(3'd1, 8'h06);
      cap_b     = cap_n;
      fall_base = fall_n;
      wr(3'd0, 8'h50);
      repeat (10) @(negedge clk);
      wr(3'd0, 8'h4F);
      wait_idle(cyc);
      chk("R7 length unchanged", 64'(cyc), 64'(2 * HF * 8 - 11));
      repeat (300) @(negedge clk);
      chk("R7 no restart", 64'(spi_cs_n), 64'd1);
      chk("R7 bit count", 64'(cap_n - cap_b), 64'd8);
      chk("R7 wire byte", 64'(cap[7:0]), 64'h06);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule